// File: doc/BRIEF.md
# Arithmetic Unit with Status Flags

This block is the execute stage for a small set of data instructions: plain copy, addition, subtraction, compare and increment. Each instruction works on two operands of the same width, either a byte or a word, chosen by a size input. The block receives the already-fetched destination and source values, the operation code and the current status flags. It produces the result, a strobe saying whether the destination must be written, and the new set of six status flags.

A single adder serves every arithmetic operation. Subtraction is done by inverting the source and injecting a carry. For byte operations the operands are cut to their low byte, and the carry, sign and overflow flags are taken from the byte boundary instead of the word boundary. Compare runs the subtraction for its flags only. Copy leaves the flags exactly as they came in. Increment keeps the incoming carry flag.

Results are registered. An operation presented with `issue` high appears on the outputs one clock later. Operand fetch, register storage and memory access belong to the surrounding datapath.

Top module: `alu_flag_unit`

## Requirements
- R1: While `rst_n` is low, `result`, `flags_out` and `wr_en` are all zero.
- R2: Operation code 0 (copy) returns the size-masked source value, asserts `wr_en`, and returns `flags_in` unchanged.
- R3: Operation code 1 (add) returns destination plus source at the selected size and asserts `wr_en`. CF is the carry out of the top bit and OF flags signed overflow.
- R4: Operation code 2 (subtract) returns destination minus source at the selected size and asserts `wr_en`. CF is set on a borrow, meaning destination below source unsigned, and OF flags signed overflow.
- R5: Operation code 3 (compare) produces the same flags and `result` value as subtract, but keeps `wr_en` low.
- R6: Operation code 4 (increment) returns destination plus one and asserts `wr_en`. It updates every flag except CF, which is copied from `flags_in`.
- R7: With `wide` = 0, only bits 7:0 of each operand are used and `result[15:8]` is zero. CF, SF and OF then refer to bit 7. With `wide` = 1, they refer to bit 15.
- R8: The flag bits are laid out as CF at bit 0, PF at bit 1, AF at bit 2, ZF at bit 3, SF at bit 4 and OF at bit 5.
  - PF is set when `result[7:0]` holds an even number of ones.
  - AF is the carry (or borrow, for subtract and compare) out of bit 3.
  - ZF is set when the sized result is zero.
  - SF is the sized result's top bit.
- R9: Operation codes 5 to 7 are no-ops: `wr_en` stays low, `result` is zero and `flags_out` equals `flags_in`.
- R10: Outputs update on the clock edge where `issue` is high. In a cycle after `issue` was low, `wr_en` is low and `result` and `flags_out` keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| issue | input | 1 | Execute the presented operation on this edge |
| op | input | 3 | Operation code (0 copy, 1 add, 2 subtract, 3 compare, 4 increment) |
| wide | input | 1 | Operand size: 0 byte, 1 word |
| dst_val | input | 16 | Destination operand value |
| src_val | input | 16 | Source operand value |
| flags_in | input | 6 | Current status flags |
| result | output | 16 | Registered result |
| wr_en | output | 1 | Destination write strobe |
| flags_out | output | 6 | Updated status flags |

## Verification
Directed cases aim at the edges where flag sources differ:
- The byte and word values at the signed limit (0x7F, 0x7FFF, 0x80, 0x8000) separate overflow from carry.
- All-ones plus one separates carry from zero.
- Zero minus one exercises borrow.
- Equal operands under compare confirm that zero is set while nothing is written.
- An increment of all-ones with CF both set and clear shows the carry is preserved rather than computed.
- Copy with arbitrary incoming flags shows pass-through.
- An unassigned code checks the no-op path.

Random operations over all eight codes and both sizes, with random flags and idle gaps, then mix nibble carries, parity patterns and hold cycles. These catch a flag taken from the wrong bit or the wrong size.

// File: rtl/alu_flag_pkg.sv
package alu_flag_pkg;

  typedef enum logic [2:0] {
    OP_MOV = 3'd0,
    OP_ADD = 3'd1,
    OP_SUB = 3'd2,
    OP_CMP = 3'd3,
    OP_INC = 3'd4
  } alu_op_e;

  localparam int FLAG_W = 6;
  localparam int FL_CF  = 0;
  localparam int FL_PF  = 1;
  localparam int FL_AF  = 2;
  localparam int FL_ZF  = 3;
  localparam int FL_SF  = 4;
  localparam int FL_OF  = 5;

endpackage

// File: rtl/alu_addsub.sv
// Shared adder: a + (sub ? ~b : b) + sub, exposing the carries the flag
// logic needs at the nibble, byte and word boundaries.
module alu_addsub #(
  parameter int W  = 16,
  parameter int NW = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sub,
  output logic [W-1:0] sum,
  output logic         c_nib,    // carry into bit 4
  output logic         c_n_in,   // carry into bit NW-1
  output logic         c_n_out,  // carry into bit NW
  output logic         c_w_in,   // carry into bit W-1
  output logic         c_w_out   // carry out of bit W-1
);
  logic [W-1:0] b_eff;
  logic [W:0]   sum_ext;

  always_comb begin
    b_eff   = sub ? ~b : b;
    sum_ext = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, sub};
    sum     = sum_ext[W-1:0];
    c_nib   = sum_ext[4]    ^ a[4]    ^ b_eff[4];
    c_n_in  = sum_ext[NW-1] ^ a[NW-1] ^ b_eff[NW-1];
    c_n_out = sum_ext[NW]   ^ a[NW]   ^ b_eff[NW];
    c_w_in  = sum_ext[W-1]  ^ a[W-1]  ^ b_eff[W-1];
    c_w_out = sum_ext[W];
  end
endmodule

// File: rtl/alu_flag_gen.sv
// Builds the six arithmetic flags from the adder outputs at the chosen size.
module alu_flag_gen
  import alu_flag_pkg::*;
#(
  parameter int W  = 16,
  parameter int NW = 8
) (
  input  logic [W-1:0]      sum,
  input  logic              sub,
  input  logic              wide,
  input  logic              c_nib,
  input  logic              c_n_in,
  input  logic              c_n_out,
  input  logic              c_w_in,
  input  logic              c_w_out,
  output logic [FLAG_W-1:0] flags
);
  localparam logic [W-1:0] NMASK = {{(W-NW){1'b0}}, {NW{1'b1}}};

  logic [W-1:0] sized;
  logic         top_in, top_out, msb;

  always_comb begin
    sized   = wide ? sum : (sum & NMASK);
    top_in  = wide ? c_w_in  : c_n_in;
    top_out = wide ? c_w_out : c_n_out;
    msb     = wide ? sum[W-1] : sum[NW-1];

    flags        = '0;
    flags[FL_CF] = top_out ^ sub;
    flags[FL_PF] = ~^sum[7:0];
    flags[FL_AF] = c_nib ^ sub;
    flags[FL_ZF] = (sized == '0);
    flags[FL_SF] = msb;
    flags[FL_OF] = top_in ^ top_out;
  end
endmodule

// File: rtl/alu_flag_unit.sv
module alu_flag_unit
  import alu_flag_pkg::*;
#(
  parameter int W  = 16,
  parameter int NW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              issue,
  input  logic [2:0]        op,
  input  logic              wide,
  input  logic [W-1:0]      dst_val,
  input  logic [W-1:0]      src_val,
  input  logic [FLAG_W-1:0] flags_in,
  output logic [W-1:0]      result,
  output logic              wr_en,
  output logic [FLAG_W-1:0] flags_out
);
  localparam logic [W-1:0] NMASK = {{(W-NW){1'b0}}, {NW{1'b1}}};
  localparam logic [W-1:0] ONE   = {{(W-1){1'b0}}, 1'b1};

  logic [W-1:0]      a_m, b_m, b_sel, sum, sum_m;
  logic              is_sub;
  logic              c_nib, c_n_in, c_n_out, c_w_in, c_w_out;
  logic [FLAG_W-1:0] raw_flags;

  logic [W-1:0]      nxt_res;
  logic              nxt_wr;
  logic [FLAG_W-1:0] nxt_fl;

  logic [W-1:0]      res_d, res_q;
  logic              wr_d, wr_q;
  logic [FLAG_W-1:0] fl_d, fl_q;

  // operand sizing and adder input selection
  always_comb begin
    a_m    = wide ? dst_val : (dst_val & NMASK);
    b_m    = wide ? src_val : (src_val & NMASK);
    is_sub = (op == OP_SUB) || (op == OP_CMP);
    b_sel  = (op == OP_INC) ? ONE : b_m;
  end

  alu_addsub #(.W(W), .NW(NW)) u_addsub (
    .a       (a_m),
    .b       (b_sel),
    .sub     (is_sub),
    .sum     (sum),
    .c_nib   (c_nib),
    .c_n_in  (c_n_in),
    .c_n_out (c_n_out),
    .c_w_in  (c_w_in),
    .c_w_out (c_w_out)
  );

  alu_flag_gen #(.W(W), .NW(NW)) u_flags (
    .sum     (sum),
    .sub     (is_sub),
    .wide    (wide),
    .c_nib   (c_nib),
    .c_n_in  (c_n_in),
    .c_n_out (c_n_out),
    .c_w_in  (c_w_in),
    .c_w_out (c_w_out),
    .flags   (raw_flags)
  );

  // operation decode
  always_comb begin
    sum_m = wide ? sum : (sum & NMASK);
    case (op)
      OP_MOV: begin
        nxt_res = b_m;
        nxt_wr  = 1'b1;
        nxt_fl  = flags_in;
      end
      OP_ADD, OP_SUB: begin
        nxt_res = sum_m;
        nxt_wr  = 1'b1;
        nxt_fl  = raw_flags;
      end
      OP_CMP: begin
        nxt_res = sum_m;
        nxt_wr  = 1'b0;
        nxt_fl  = raw_flags;
      end
      OP_INC: begin
        nxt_res = sum_m;
        nxt_wr  = 1'b1;
        nxt_fl  = {raw_flags[FLAG_W-1:1], flags_in[FL_CF]};
      end
      default: begin
        nxt_res = '0;
        nxt_wr  = 1'b0;
        nxt_fl  = flags_in;
      end
    endcase
  end

  // next-state with explicit clock enable
  always_comb begin
    res_d = issue ? nxt_res : res_q;
    fl_d  = issue ? nxt_fl  : fl_q;
    wr_d  = issue & nxt_wr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q <= '0;
      wr_q  <= 1'b0;
      fl_q  <= '0;
    end else begin
      res_q <= res_d;
      wr_q  <= wr_d;
      fl_q  <= fl_d;
    end
  end

  assign result    = res_q;
  assign wr_en     = wr_q;
  assign flags_out = fl_q;

endmodule

// File: rtl/alu_flag_unit_chk.sv
module alu_flag_unit_chk
  import alu_flag_pkg::*;
#(
  parameter int W  = 16,
  parameter int NW = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              issue,
  input logic [2:0]        op,
  input logic              wide,
  input logic [W-1:0]      src_val,
  input logic [FLAG_W-1:0] flags_in,
  input logic [W-1:0]      result,
  input logic              wr_en,
  input logic [FLAG_W-1:0] flags_out
);
  localparam logic [W-1:0] NMASK = {{(W-NW){1'b0}}, {NW{1'b1}}};

  // R1: outputs cleared while reset is held
  always_comb begin
    if (!rst_n) begin
      a_r1_reset_clear: assert (result == '0 && !wr_en && flags_out == '0);
    end
  end

  // R2: copy returns the sized source and the incoming flags
  a_r2_mov_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && op == OP_MOV) |=>
      (flags_out == $past(flags_in) && wr_en &&
       result == ($past(wide) ? $past(src_val) : ($past(src_val) & NMASK))));

  // R5: compare never writes
  a_r5_cmp_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && op == OP_CMP) |=> !wr_en);

  // R6: increment keeps the carry flag
  a_r6_inc_keep_cf: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && op == OP_INC) |=> (flags_out[FL_CF] == $past(flags_in[FL_CF])));

  // R7: byte results have a clear upper byte
  a_r7_byte_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && !wide) |=> (result[W-1:NW] == '0));

  // R9: unassigned codes neither write nor touch the flags
  a_r9_nop_codes: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && op > 3'd4) |=> (!wr_en && flags_out == $past(flags_in)));

  // R10: without issue the outputs hold and nothing is written
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !issue |=> (!wr_en && $stable(result) && $stable(flags_out)));

endmodule

bind alu_flag_unit alu_flag_unit_chk #(.W(W), .NW(NW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .issue     (issue),
  .op        (op),
  .wide      (wide),
  .src_val   (src_val),
  .flags_in  (flags_in),
  .result    (result),
  .wr_en     (wr_en),
  .flags_out (flags_out)
);

// File: tb/alu_flag_unit_tb.sv
`timescale 1ns/1ps
module alu_flag_unit_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        issue;
  logic [2:0]  op;
  logic        wide;
  logic [15:0] dst_val, src_val;
  logic [5:0]  flags_in;
  logic [15:0] result;
  logic        wr_en;
  logic [5:0]  flags_out;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  logic [15:0] last_res;
  logic [5:0]  last_fl;

  always #5 clk = ~clk;

  alu_flag_unit u_dut (
    .clk(clk), .rst_n(rst_n), .issue(issue), .op(op), .wide(wide),
    .dst_val(dst_val), .src_val(src_val), .flags_in(flags_in),
    .result(result), .wr_en(wr_en), .flags_out(flags_out)
  );

  // reference: returns {wr, flags[5:0], res[15:0]}
  // flags: bit0 CF, bit1 PF, bit2 AF, bit3 ZF, bit4 SF, bit5 OF
  function automatic logic [22:0] ref_model(input logic [2:0] o, input logic w,
                                            input logic [15:0] d, input logic [15:0] s,
                                            input logic [5:0] fin);
    logic [15:0] m, dd, ss, r;
    logic [16:0] full;
    logic cf, af, of, sd, sb, sr, wr;
    logic [5:0] fl;
    int n;
    n  = w ? 16 : 8;
    m  = w ? 16'hFFFF : 16'h00FF;
    dd = d & m;
    ss = s & m;
    r = '0; cf = 1'b0; af = 1'b0; of = 1'b0; wr = 1'b0; fl = fin;
    if (o == 3'd0) begin
      return {1'b1, fin, ss};
    end else if (o == 3'd1 || o == 3'd4) begin
      if (o == 3'd4) ss = 16'd1;
      full = {1'b0, dd} + {1'b0, ss};
      r  = full[15:0] & m;
      cf = w ? full[16] : full[8];
      af = ({1'b0, dd[3:0]} + {1'b0, ss[3:0]}) > 5'd15;
      sd = dd[n-1]; sb = ss[n-1]; sr = r[n-1];
      of = (sd == sb) && (sr != sd);
      if (o == 3'd4) cf = fin[0];
      wr = 1'b1;
    end else if (o == 3'd2 || o == 3'd3) begin
      r  = (dd - ss) & m;
      cf = dd < ss;
      af = dd[3:0] < ss[3:0];
      sd = dd[n-1]; sb = ss[n-1]; sr = r[n-1];
      of = (sd != sb) && (sr != sd);
      wr = (o == 3'd2);
    end else begin
      return {1'b0, fin, 16'h0000};
    end
    fl = {of, r[n-1], (r == 16'h0), af, ~^r[7:0], cf};
    return {wr, fl, r};
  endfunction

  function automatic string tag_of(input logic [2:0] o, input logic w);
    if (!w && o <= 3'd4) return "R7";
    case (o)
      3'd0: return "R2";
      3'd1: return "R3";
      3'd2: return "R4";
      3'd3: return "R5";
      3'd4: return "R6";
      default: return "R9";
    endcase
  endfunction

  task automatic check(input string tag, input logic [15:0] er,
                       input logic ew, input logic [5:0] ef);
    n_chk++;
    if (result !== er || wr_en !== ew || flags_out !== ef) begin
      n_bad++;
      $display("FAIL %s: got res=%h wr=%b fl=%b, expected res=%h wr=%b fl=%b",
               tag, result, wr_en, flags_out, er, ew, ef);
    end
  endtask

  task automatic run_op(input string tag, input logic [2:0] o, input logic w,
                        input logic [15:0] d, input logic [15:0] s,
                        input logic [5:0] fin);
    logic [22:0] e;
    @(negedge clk);
    issue = 1'b1; op = o; wide = w; dst_val = d; src_val = s; flags_in = fin;
    e = ref_model(o, w, d, s, fin);
    @(posedge clk); #1;
    check(tag, e[15:0], e[22], e[21:16]);
    last_res = e[15:0];
    last_fl  = e[21:16];
  endtask

  task automatic idle_cycle();
    @(negedge clk);
    issue = 1'b0;
    op = 3'($urandom_range(0, 7)); wide = 1'($urandom);
    dst_val = 16'($urandom); src_val = 16'($urandom); flags_in = 6'($urandom);
    @(posedge clk); #1;
    check("R10", last_res, 1'b0, last_fl);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      n_chk++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20250101));
    rst_n = 1'b0; issue = 1'b0; op = '0; wide = 1'b0;
    dst_val = '0; src_val = '0; flags_in = 6'h3F;
    repeat (3) @(posedge clk);
    #1;
    check("R1", 16'h0000, 1'b0, 6'h00);
    @(negedge clk);
    rst_n = 1'b1;

    // directed corners
    run_op("R2",  3'd0, 1'b1, 16'h1234, 16'hBEEF, 6'b101010);
    run_op("R7",  3'd0, 1'b0, 16'h1234, 16'hBEEF, 6'b010101);
    run_op("R3",  3'd1, 1'b0, 16'h007F, 16'h0001, 6'h00); // byte signed overflow
    run_op("R3",  3'd1, 1'b0, 16'h00FF, 16'h0001, 6'h00); // byte carry and zero
    run_op("R3",  3'd1, 1'b1, 16'h7FFF, 16'h0001, 6'h00); // word signed overflow
    run_op("R3",  3'd1, 1'b1, 16'hFFFF, 16'h0001, 6'h00); // word carry and zero
    run_op("R8",  3'd1, 1'b1, 16'h0008, 16'h0008, 6'h00); // nibble carry, parity
    run_op("R4",  3'd2, 1'b1, 16'h8000, 16'h0001, 6'h00); // word sub overflow
    run_op("R4",  3'd2, 1'b1, 16'h0000, 16'h0001, 6'h00); // borrow
    run_op("R7",  3'd2, 1'b0, 16'hAB80, 16'hCD01, 6'h00); // byte sub overflow
    run_op("R5",  3'd3, 1'b1, 16'h5A5A, 16'h5A5A, 6'h3F); // equal compare
    run_op("R5",  3'd3, 1'b0, 16'h0010, 16'h0020, 6'h00);
    run_op("R6",  3'd4, 1'b1, 16'hFFFF, 16'h0000, 6'h01); // keep CF set
    run_op("R6",  3'd4, 1'b1, 16'hFFFF, 16'h0000, 6'h00); // keep CF clear
    run_op("R6",  3'd4, 1'b0, 16'h007F, 16'h0000, 6'h00);
    run_op("R9",  3'd5, 1'b1, 16'h1111, 16'h2222, 6'b110011);
    run_op("R9",  3'd7, 1'b0, 16'h1111, 16'h2222, 6'b001100);
    idle_cycle();
    idle_cycle();

    // random mix
    for (int i = 0; i < 400; i++) begin
      logic [2:0] o;
      logic w;
      o = 3'($urandom_range(0, 7));
      w = 1'($urandom);
      if ($urandom_range(0, 7) == 0) idle_cycle();
      run_op(tag_of(o, w), o, w, 16'($urandom), 16'($urandom), 6'($urandom));
    end

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule